// File: doc/BRIEF.md
# Send DMA Engine Sequencer

This block is the control state machine that walks a send DMA engine through its life cycle: powered-down, waiting for hardware start-up, idle, running, waiting for a halt, waiting for hardware clean-up and waiting for software clean-up. Neighbouring logic reports progress to it as one-cycle event pulses, each carrying an event code. The sequencer answers with a set of engine control levels and with one-cycle request pulses that start the real work in other blocks. That work is hardware start-up (including disarming the send buffers), hardware clean-up and software clean-up.

A sticky "go running" flag records whether the engine should run once start-up completes. Wait states do not drop a run or idle request. They fold it into the flag instead. Two kinds of error halt recover differently. One goes straight to software clean-up. The other first waits for the hardware to report that it has halted.

A started indication is set when the engine leaves the powered-down state and is cleared when the sequencer tears down. Each clear is marked by a teardown pulse. For debug, the previous state and the last event code are held in registers.

Top module: `dma_seq_ctrl`

## Requirements
- R1: After reset, the outputs are as follows: state_o is 0, go_run_o, started_o, all engine control bits, all request pulses and teardown_o are 0, prev_state_o is 0 and last_evt_o is 15. The state codes are: 0 down, 1 start-up wait, 2 idle, 3 software clean-up wait, 4 hardware clean-up wait, 5 halt wait, 6 running. The event codes are: 0 go down, 1 go start, 2 hardware started, 3 go running, 4 software cleaned, 5 hardware cleaned, 6 hardware halted, 7 go idle, 8 error type A, 9 error type B, 10 timer tick; codes 11 to 15 are unused.
- R2: In down, go start moves to start-up wait and sets started_o. Go running does the same and also sets go_run_o.
- R3: In start-up wait, hardware started moves to running when go_run_o is 1 and to idle otherwise. Go running sets the flag and go idle clears it, and neither changes the state.
- R4: In idle, go running moves to running and sets go_run_o.
- R5: In running, go idle moves to halt wait and clears go_run_o. Error type B moves to halt wait and leaves the flag unchanged.
- R6: In running, hardware halted or error type A moves to software clean-up wait and pulses req_sw_clean_o.
- R7: In halt wait, hardware halted moves to hardware clean-up wait and pulses req_hw_clean_o. In hardware clean-up wait, hardware cleaned moves to software clean-up wait and pulses req_sw_clean_o.
- R8: In software clean-up wait, software cleaned moves to start-up wait and pulses req_hw_start_o.
- R9: Go down moves every state other than down to down. It pulses req_sw_clean_o only from running, halt wait or hardware clean-up wait. From start-up wait or idle, it clears started_o and pulses teardown_o.
- R10: In down, software cleaned clears started_o and pulses teardown_o without changing the state.
- R11: In software clean-up, hardware clean-up and halt wait, go running sets go_run_o and go idle clears it, and the state does not change.
- R12: The engine control bits depend on the state as follows. eng_en_o is 1 only in running. eng_irq_en_o is 1 in idle and running. eng_halt_o is 1 in halt wait and in both clean-up waits. eng_drain_o is 1 only in halt wait.
- R13: Request and teardown pulses last exactly one cycle, and at most one request is active at a time. Any event not named above for the current state, including timer tick and unused codes, changes no output except last_evt_o.
- R14: On every state change, prev_state_o takes the state being left. On every valid event, last_evt_o takes its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_vld_i | input | 1 | Event pulse valid |
| evt_code_i | input | 4 | Event code |
| state_o | output | 3 | Current state code |
| go_run_o | output | 1 | Sticky go-running flag |
| started_o | output | 1 | Engine started indication |
| eng_en_o | output | 1 | Engine enable |
| eng_irq_en_o | output | 1 | Engine interrupt enable |
| eng_halt_o | output | 1 | Engine halt |
| eng_drain_o | output | 1 | Engine drain |
| req_hw_start_o | output | 1 | Hardware start-up request pulse |
| req_hw_clean_o | output | 1 | Hardware clean-up request pulse |
| req_sw_clean_o | output | 1 | Software clean-up request pulse |
| teardown_o | output | 1 | Teardown pulse |
| prev_state_o | output | 3 | State left on the last transition |
| last_evt_o | output | 4 | Code of the last valid event |

## Verification
Every reachable state is entered through short event paths. Halt wait is entered with the flag both set and cleared, and down is entered with started_o both clear and still set. In each of these, all sixteen event codes are applied. This tells the two error recoveries apart, the two exits from start-up wait, the three flavours of go down, and the handled events from the ignored ones. After each final event, one quiet cycle confirms that the pulses drop and the state holds.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int ST_W  = 3;
  localparam int EVT_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_DOWN    = 3'd0,
    ST_STARTUP = 3'd1,
    ST_IDLE    = 3'd2,
    ST_SWCLN   = 3'd3,
    ST_HWCLN   = 3'd4,
    ST_HALTW   = 3'd5,
    ST_RUN     = 3'd6
  } seq_state_e;

  localparam logic [EVT_W-1:0] EV_DOWN       = 4'd0;
  localparam logic [EVT_W-1:0] EV_START      = 4'd1;
  localparam logic [EVT_W-1:0] EV_HW_STARTED = 4'd2;
  localparam logic [EVT_W-1:0] EV_RUN        = 4'd3;
  localparam logic [EVT_W-1:0] EV_SW_CLEANED = 4'd4;
  localparam logic [EVT_W-1:0] EV_HW_CLEANED = 4'd5;
  localparam logic [EVT_W-1:0] EV_HW_HALTED  = 4'd6;
  localparam logic [EVT_W-1:0] EV_IDLE       = 4'd7;
  localparam logic [EVT_W-1:0] EV_ERR_A      = 4'd8;
  localparam logic [EVT_W-1:0] EV_ERR_B      = 4'd9;
  localparam logic [EVT_W-1:0] EV_TICK       = 4'd10;

  typedef struct packed {
    logic en;
    logic irq_en;
    logic halt;
    logic drain;
  } seq_ctl_t;
endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_vld_i,
  input  logic [EVT_W-1:0] evt_code_i,
  output seq_state_e       state_o,
  output logic             go_run_o,
  output logic             started_o,
  output logic             req_hw_start_o,
  output logic             req_hw_clean_o,
  output logic             req_sw_clean_o,
  output logic             teardown_o
);
  seq_state_e st_q, st_d;
  logic flag_q, flag_d, started_q, started_d;
  logic hws_d, hwc_d, swc_d, td_d;
  logic hws_q, hwc_q, swc_q, td_q;

  always_comb begin
    st_d      = st_q;
    flag_d    = flag_q;
    started_d = started_q;
    hws_d = 1'b0;
    hwc_d = 1'b0;
    swc_d = 1'b0;
    td_d  = 1'b0;
    if (evt_vld_i) begin
      if (evt_code_i == EV_DOWN) begin
        if (st_q != ST_DOWN) begin
          st_d = ST_DOWN;
          if (st_q inside {ST_RUN, ST_HALTW, ST_HWCLN}) swc_d = 1'b1;
          if (st_q inside {ST_STARTUP, ST_IDLE}) begin
            started_d = 1'b0;
            td_d      = 1'b1;
          end
        end
      end else begin
        case (st_q)
          ST_DOWN: begin
            case (evt_code_i)
              EV_START: begin st_d = ST_STARTUP; started_d = 1'b1; end
              EV_RUN: begin st_d = ST_STARTUP; started_d = 1'b1; flag_d = 1'b1; end
              EV_SW_CLEANED: begin started_d = 1'b0; td_d = 1'b1; end
              default: ;
            endcase
          end
          ST_STARTUP: begin
            case (evt_code_i)
              EV_HW_STARTED: st_d = flag_q ? ST_RUN : ST_IDLE;
              EV_RUN:        flag_d = 1'b1;
              EV_IDLE:       flag_d = 1'b0;
              default: ;
            endcase
          end
          ST_IDLE: begin
            if (evt_code_i == EV_RUN) begin
              st_d   = ST_RUN;
              flag_d = 1'b1;
            end
          end
          ST_RUN: begin
            case (evt_code_i)
              EV_HW_HALTED, EV_ERR_A: begin st_d = ST_SWCLN; swc_d = 1'b1; end
              EV_IDLE:  begin st_d = ST_HALTW; flag_d = 1'b0; end
              EV_ERR_B: st_d = ST_HALTW;
              default: ;
            endcase
          end
          ST_HALTW: begin
            case (evt_code_i)
              EV_HW_HALTED: begin st_d = ST_HWCLN; hwc_d = 1'b1; end
              EV_RUN:  flag_d = 1'b1;
              EV_IDLE: flag_d = 1'b0;
              default: ;
            endcase
          end
          ST_HWCLN: begin
            case (evt_code_i)
              EV_HW_CLEANED: begin st_d = ST_SWCLN; swc_d = 1'b1; end
              EV_RUN:  flag_d = 1'b1;
              EV_IDLE: flag_d = 1'b0;
              default: ;
            endcase
          end
          ST_SWCLN: begin
            case (evt_code_i)
              EV_SW_CLEANED: begin st_d = ST_STARTUP; hws_d = 1'b1; end
              EV_RUN:  flag_d = 1'b1;
              EV_IDLE: flag_d = 1'b0;
              default: ;
            endcase
          end
          default: st_d = ST_DOWN;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_DOWN;
      flag_q    <= 1'b0;
      started_q <= 1'b0;
      hws_q     <= 1'b0;
      hwc_q     <= 1'b0;
      swc_q     <= 1'b0;
      td_q      <= 1'b0;
    end else begin
      st_q      <= st_d;
      flag_q    <= flag_d;
      started_q <= started_d;
      hws_q     <= hws_d;
      hwc_q     <= hwc_d;
      swc_q     <= swc_d;
      td_q      <= td_d;
    end
  end

  assign state_o        = st_q;
  assign go_run_o       = flag_q;
  assign started_o      = started_q;
  assign req_hw_start_o = hws_q;
  assign req_hw_clean_o = hwc_q;
  assign req_sw_clean_o = swc_q;
  assign teardown_o     = td_q;

  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hws_q, hwc_q, swc_q})); // R13
  AST_DOWN_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_i && evt_code_i == EV_DOWN) |=> (st_q == ST_DOWN)); // R9
  AST_START_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_i && evt_code_i == EV_HW_STARTED && st_q == ST_STARTUP && flag_q)
      |=> (st_q == ST_RUN)); // R3
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_vld_i |=> ($stable(st_q) && !hws_q && !hwc_q && !swc_q && !td_q)); // R13
  AST_WAIT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_i && evt_code_i == EV_RUN && st_q inside {ST_SWCLN, ST_HWCLN, ST_HALTW})
      |=> (flag_q && $stable(st_q))); // R11
endmodule

// File: rtl/dma_seq_ctl_dec.sv
module dma_seq_ctl_dec
  import dma_seq_pkg::*;
(
  input  seq_state_e state_i,
  output seq_ctl_t   ctl_o
);
  always_comb begin
    ctl_o        = '0;
    ctl_o.en     = (state_i == ST_RUN);
    ctl_o.irq_en = (state_i inside {ST_IDLE, ST_RUN});
    ctl_o.halt   = (state_i inside {ST_HALTW, ST_HWCLN, ST_SWCLN});
    ctl_o.drain  = (state_i == ST_HALTW);
  end
endmodule

// File: rtl/dma_seq_trace.sv
module dma_seq_trace
  import dma_seq_pkg::*;
#(
  parameter logic [EVT_W-1:0] NO_EVT = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_vld_i,
  input  logic [EVT_W-1:0] evt_code_i,
  input  seq_state_e       state_i,
  output seq_state_e       prev_state_o,
  output logic [EVT_W-1:0] last_evt_o
);
  seq_state_e cur_q, prev_q;
  logic [EVT_W-1:0] evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= ST_DOWN;
      prev_q <= ST_DOWN;
      evt_q  <= NO_EVT;
    end else begin
      cur_q <= state_i;
      if (state_i != cur_q) prev_q <= cur_q;
      if (evt_vld_i) evt_q <= evt_code_i;
    end
  end

  // cur_q lags the live state by one cycle, so prev updates in the same cycle as the move is seen
  always_comb begin
    prev_state_o = prev_q;
    if (state_i != cur_q) prev_state_o = cur_q;
  end
  assign last_evt_o = evt_q;

  AST_PREV_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != $past(state_i)) |-> (prev_state_o == $past(state_i))); // R14
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter logic [EVT_W-1:0] NO_EVT = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_vld_i,
  input  logic [EVT_W-1:0] evt_code_i,
  output logic [ST_W-1:0]  state_o,
  output logic             go_run_o,
  output logic             started_o,
  output logic             eng_en_o,
  output logic             eng_irq_en_o,
  output logic             eng_halt_o,
  output logic             eng_drain_o,
  output logic             req_hw_start_o,
  output logic             req_hw_clean_o,
  output logic             req_sw_clean_o,
  output logic             teardown_o,
  output logic [ST_W-1:0]  prev_state_o,
  output logic [EVT_W-1:0] last_evt_o
);
  seq_state_e st, prev_st;
  seq_ctl_t   ctl;

  dma_seq_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .evt_vld_i      (evt_vld_i),
    .evt_code_i     (evt_code_i),
    .state_o        (st),
    .go_run_o       (go_run_o),
    .started_o      (started_o),
    .req_hw_start_o (req_hw_start_o),
    .req_hw_clean_o (req_hw_clean_o),
    .req_sw_clean_o (req_sw_clean_o),
    .teardown_o     (teardown_o)
  );

  dma_seq_ctl_dec u_dec (
    .state_i (st),
    .ctl_o   (ctl)
  );

  dma_seq_trace #(.NO_EVT(NO_EVT)) u_trace (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_vld_i    (evt_vld_i),
    .evt_code_i   (evt_code_i),
    .state_i      (st),
    .prev_state_o (prev_st),
    .last_evt_o   (last_evt_o)
  );

  assign state_o      = st;
  assign prev_state_o = prev_st;
  assign eng_en_o     = ctl.en;
  assign eng_irq_en_o = ctl.irq_en;
  assign eng_halt_o   = ctl.halt;
  assign eng_drain_o  = ctl.drain;

  AST_EN_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_en_o |-> go_run_o); // R12
  AST_HALT_NOT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_sw_clean_o |-> !eng_en_o); // R6
endmodule

// File: tb/dma_seq_ctrl_tb.sv
`timescale 1ns/1ps
module dma_seq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       evt_vld_i = 1'b0;
  logic [3:0] evt_code_i = 4'd0;
  logic [2:0] state_o, prev_state_o;
  logic [3:0] last_evt_o;
  logic go_run_o, started_o, eng_en_o, eng_irq_en_o, eng_halt_o, eng_drain_o;
  logic req_hw_start_o, req_hw_clean_o, req_sw_clean_o, teardown_o;

  int n_chk = 0;
  int n_fail = 0;

  // model state
  int m_st, m_flag, m_started, m_prev, m_last;
  int m_hws, m_hwc, m_swc, m_td;

  always #2.5 clk_i = ~clk_i;

  dma_seq_ctrl u_dut (
    .clk_i, .rst_ni, .evt_vld_i, .evt_code_i, .state_o, .go_run_o, .started_o,
    .eng_en_o, .eng_irq_en_o, .eng_halt_o, .eng_drain_o, .req_hw_start_o,
    .req_hw_clean_o, .req_sw_clean_o, .teardown_o, .prev_state_o, .last_evt_o
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string req_tag(input int s, input int c);
    if (c == 0) return (s == 0) ? "R13" : "R9";
    case (s)
      0: return (c == 1 || c == 3) ? "R2" : (c == 4) ? "R10" : "R13";
      1: return (c == 2 || c == 3 || c == 7) ? "R3" : "R13";
      2: return (c == 3) ? "R4" : "R13";
      6: return (c == 7 || c == 9) ? "R5" : (c == 6 || c == 8) ? "R6" : "R13";
      5: return (c == 6) ? "R7" : (c == 3 || c == 7) ? "R11" : "R13";
      4: return (c == 5) ? "R7" : (c == 3 || c == 7) ? "R11" : "R13";
      3: return (c == 4) ? "R8" : (c == 3 || c == 7) ? "R11" : "R13";
      default: return "R13";
    endcase
  endfunction

  task automatic model_step(input int c);
    int s;
    s = m_st;
    m_hws = 0; m_hwc = 0; m_swc = 0; m_td = 0;
    m_last = c;
    if (c == 0) begin
      if (s != 0) begin
        m_st = 0;
        if (s == 6 || s == 5 || s == 4) m_swc = 1;
        if (s == 1 || s == 2) begin m_started = 0; m_td = 1; end
      end
    end else begin
      case (s)
        0: if (c == 1) begin m_st = 1; m_started = 1; end
           else if (c == 3) begin m_st = 1; m_started = 1; m_flag = 1; end
           else if (c == 4) begin m_started = 0; m_td = 1; end
        1: if (c == 2) m_st = m_flag ? 6 : 2;
           else if (c == 3) m_flag = 1;
           else if (c == 7) m_flag = 0;
        2: if (c == 3) begin m_st = 6; m_flag = 1; end
        6: if (c == 6 || c == 8) begin m_st = 3; m_swc = 1; end
           else if (c == 7) begin m_st = 5; m_flag = 0; end
           else if (c == 9) m_st = 5;
        5: if (c == 6) begin m_st = 4; m_hwc = 1; end
           else if (c == 3) m_flag = 1;
           else if (c == 7) m_flag = 0;
        4: if (c == 5) begin m_st = 3; m_swc = 1; end
           else if (c == 3) m_flag = 1;
           else if (c == 7) m_flag = 0;
        3: if (c == 4) begin m_st = 1; m_hws = 1; end
           else if (c == 3) m_flag = 1;
           else if (c == 7) m_flag = 0;
        default: ;
      endcase
    end
    if (m_st != s) m_prev = s;
  endtask

  task automatic check_all(input string tag);
    chk(tag, "state", state_o, m_st);
    chk(tag, "go_run", go_run_o, m_flag);
    chk(tag, "started", started_o, m_started);
    chk(tag, "req_hw_start", req_hw_start_o, m_hws);
    chk(tag, "req_hw_clean", req_hw_clean_o, m_hwc);
    chk(tag, "req_sw_clean", req_sw_clean_o, m_swc);
    chk(tag, "teardown", teardown_o, m_td);
    chk("R12", "eng_en", eng_en_o, int'(m_st == 6));
    chk("R12", "eng_irq_en", eng_irq_en_o, int'(m_st == 2 || m_st == 6));
    chk("R12", "eng_halt", eng_halt_o, int'(m_st == 3 || m_st == 4 || m_st == 5));
    chk("R12", "eng_drain", eng_drain_o, int'(m_st == 5));
    chk("R14", "prev_state", prev_state_o, m_prev);
    chk("R14", "last_evt", last_evt_o, m_last);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    evt_vld_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_st = 0; m_flag = 0; m_started = 0; m_prev = 0; m_last = 15;
    m_hws = 0; m_hwc = 0; m_swc = 0; m_td = 0;
    @(negedge clk_i);
    check_all("R1");
  endtask

  task automatic send(input int c);
    string tag;
    tag = req_tag(m_st, c);
    evt_vld_i  = 1'b1;
    evt_code_i = 4'(c);
    @(negedge clk_i);
    evt_vld_i = 1'b0;
    model_step(c);
    check_all(tag);
  endtask

  function automatic int path_len(input int p);
    case (p)
      0: return 0;
      1, 2: return 1;
      3, 4: return 2;
      5, 6, 8, 9: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int path_evt(input int p, input int i);
    case (p)
      1: return 1;
      2: return 3;
      3: return (i == 0) ? 1 : 2;
      4: return (i == 0) ? 3 : 2;
      5: return (i == 0) ? 3 : (i == 1) ? 2 : 9;
      6: return (i == 0) ? 3 : (i == 1) ? 2 : 7;
      7: return (i == 0) ? 3 : (i == 1) ? 2 : (i == 2) ? 7 : 6;
      8: return (i == 0) ? 3 : (i == 1) ? 2 : 8;
      9: return (i == 0) ? 3 : (i == 1) ? 2 : 0;
      default: return 10;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    for (int p = 0; p < 10; p++) begin
      for (int c = 0; c < 16; c++) begin
        do_reset();
        for (int i = 0; i < path_len(p); i++) send(path_evt(p, i));
        send(c);
        // quiet cycle: pulses drop, state holds
        m_hws = 0; m_hwc = 0; m_swc = 0; m_td = 0;
        @(negedge clk_i);
        check_all("R13");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule